// File: doc/BRIEF.md
# Lower-Order Path Overhead Serial Exporter

This block gathers the per-tributary lower-order path overhead bytes (V5, J2, Z6/N2, Z7/K4 and the O-bit nibbles) into a capture bank over one superframe. During the following superframe it plays them out on a single serial line as typed bursts. Each burst opens with a three-bit type code, and a burst-valid strobe frames it. Once per frame the block also samples a remote error / remote defect status word and sends it as the opening burst of that frame.

Which bursts a frame carries depends on where the frame sits in the four-frame multiframe. An upstream pointer and overhead extractor writes the bytes through a simple strobe port and supplies a frame pulse and a multiframe-start flag. A downstream serial receiver reads the typed bursts. The block is parameterised by the number of tributaries in use. Byte slots beyond that number are sent as zero.

Top module: `poh_serial_export`

The burst controller has four states. In `S_IDLE` the line is quiet. In `S_HDR` the three type bits are shifted out. In `S_STAT` the status payload is shifted out. In `S_OH` a 28-slot overhead payload is shifted out. The transitions are:

- `frame_sync` moves the controller from any state to `S_HDR`.
- At the end of a header, `S_HDR` moves to `S_STAT` for type 001 or to `S_OH` for any other type.
- At the end of a payload, `S_STAT` or `S_OH` moves to `S_HDR` when the schedule has a further burst, and to `S_IDLE` when it does not.

## Requirements
- R1: When `frame_sync` is sampled high, `stat_in` is latched. From the following cycle the frame opens with a status burst whose 34 payload bits are the latched word, most significant bit first, sent straight after its header.
- R2: Overhead written during one superframe goes into the capture bank. The capture and readout banks trade places only when frame 1 is entered directly from frame 4, so the data is read out during the next superframe.
- R3: The multiframe phase sets the burst order. Frame 1 sends 001, 010, 011, 100. Frame 2 sends 001, 101, 110. Frames 3 and 4 send 001 only. The bursts follow each other with no idle cycle between them.
- R4: Every burst starts with a 3-bit type header, sent MSB first. The codes are 001 status, 010 V5, 011 J2, 100 Z6/N2, 101 Z7/K4 and 110 O bits. Codes 000 and 111 are never sent.
- R5: `ser_valid` is high from the first header bit to the last payload bit of each burst. The header takes 3 cycles, a status payload 34 and an overhead payload 224. Whenever `ser_valid` is low, `ser_data` is 0.
- R6: Overhead payloads hold one byte per tributary, starting at tributary index 0, and each byte is sent MSB first. A write with `wr_sel` 0, 1, 2 or 3 stores `wr_data` as the V5, J2, Z6/N2 or Z7/K4 byte of tributary `wr_trib`.
- R7: The O-bit byte of a tributary carries the nibble that followed J2 in its upper four bits and the nibble that followed Z6/N2 in its lower four bits. The nibbles are written with `wr_sel` 4 and 5 respectively, from `wr_data[3:0]`.
- R8: Byte slots at or beyond `NUM_TRIB` are sent as zero, and writes to `wr_trib >= NUM_TRIB` are ignored.
- R9: Writes with `wr_sel` 6 or 7 change no stored byte.
- R10: Each `frame_sync` advances the phase 1→2→3→4→1. A `frame_sync` with `mf_first` high forces frame 1. If that happens when the current phase is not 4, the schedule restarts at frame 1 without swapping banks. `mf_first` has no effect without `frame_sync`.
- R11: A `frame_sync` that arrives while a burst is in progress abandons it, and the new frame's status burst starts on the next cycle.
- R12: After reset the line is idle (`ser_valid` 0, `ser_data` 0), all stored bytes and the status word are zero, and the phase is frame 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial channel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | One-cycle pulse at the frame alignment position |
| mf_first | input | 1 | Qualifies `frame_sync`: this frame is frame 1 of the multiframe |
| stat_in | input | STAT_W | Remote error / remote defect status word |
| wr_en | input | 1 | Overhead write strobe |
| wr_sel | input | 3 | Field select: 0 V5, 1 J2, 2 Z6/N2, 3 Z7/K4, 4 O upper nibble, 5 O lower nibble |
| wr_trib | input | $clog2(SLOTS) | Tributary index, from 0 |
| wr_data | input | 8 | Overhead byte (nibble in bits 3:0 for the O writes) |
| ser_data | output | 1 | Serial burst data |
| ser_valid | output | 1 | High while a burst bit is on `ser_data` |

## Verification
The hardest case to reach is a multiframe start that arrives out of order. The schedule must go back to frame 1 while the readout bank still holds the previous superframe's bytes, and the capture bank must keep filling undisturbed. The stimulus reaches it by running two whole multiframes to fill both banks with different data. It then asserts `mf_first` on the frame that follows a frame 2, so the repeated frame 1 must resend the old bytes bit for bit. It also cuts a frame 2 short with an early `frame_sync`, which exercises the abort path and the phase step that follows it.

// File: rtl/poh_pkg.sv
package poh_pkg;

    localparam int HDR_W  = 3;
    localparam int FIELDS = 5;
    localparam int OB_IDX = 4;

    typedef enum logic [2:0] {
        T_NONE = 3'b000,
        T_STAT = 3'b001,
        T_V5   = 3'b010,
        T_J2   = 3'b011,
        T_Z6   = 3'b100,
        T_Z7   = 3'b101,
        T_OB   = 3'b110,
        T_RSV  = 3'b111
    } burst_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HDR,
        S_STAT,
        S_OH
    } fsm_t;

    // Burst type at position idx of the frame with phase ph (0 = frame 1).
    // T_NONE marks the end of the frame's list.
    function automatic burst_t sched_pick(logic [1:0] ph, logic [2:0] idx);
        burst_t r;
        r = T_NONE;
        if (idx == 3'd0) begin
            r = T_STAT;
        end else if (ph == 2'd0) begin
            case (idx)
                3'd1:    r = T_V5;
                3'd2:    r = T_J2;
                3'd3:    r = T_Z6;
                default: r = T_NONE;
            endcase
        end else if (ph == 2'd1) begin
            case (idx)
                3'd1:    r = T_Z7;
                3'd2:    r = T_OB;
                default: r = T_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/poh_phase_track.sv
module poh_phase_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_sync,
    input  logic       mf_first,
    output logic [1:0] phase,
    output logic       cap_bank
);

    logic in_seq;

    assign in_seq = (phase == 2'd3);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase    <= 2'd3;
            cap_bank <= 1'b0;
        end else if (frame_sync) begin
            if (mf_first || in_seq) begin
                phase <= 2'd0;
            end else begin
                phase <= phase + 2'd1;
            end
            if (in_seq) begin
                cap_bank <= ~cap_bank;
            end
        end
    end

endmodule

// File: rtl/poh_bank_store.sv
module poh_bank_store
    import poh_pkg::*;
#(
    parameter int NUM_TRIB = 28,
    parameter int SLOTS    = 28,
    localparam int SLOT_W  = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [SLOT_W-1:0] wr_trib,
    input  logic [7:0]        wr_data,
    input  logic              cap_bank,
    input  logic [2:0]        rd_field,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [7:0]        rd_byte
);

    logic       wr_hit;
    logic       rd_ok;
    logic [7:0] bank_rd [2];

    assign wr_hit = wr_en && (int'(wr_trib) < NUM_TRIB);
    assign rd_ok  = (int'(rd_slot) < NUM_TRIB) && (int'(rd_field) < FIELDS);

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [7:0] mem [FIELDS][NUM_TRIB];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int f = 0; f < FIELDS; f++) begin
                    for (int t = 0; t < NUM_TRIB; t++) begin
                        mem[f][t] <= '0;
                    end
                end
            end else if (wr_hit && (cap_bank == 1'(b))) begin
                case (wr_sel)
                    3'd0, 3'd1, 3'd2, 3'd3: mem[wr_sel][wr_trib]      <= wr_data;
                    3'd4:                   mem[OB_IDX][wr_trib][7:4] <= wr_data[3:0];
                    3'd5:                   mem[OB_IDX][wr_trib][3:0] <= wr_data[3:0];
                    default: ;
                endcase
            end
        end

        assign bank_rd[b] = rd_ok ? mem[rd_field][rd_slot] : 8'h00;
    end

    assign rd_byte = bank_rd[~cap_bank];

endmodule

// File: rtl/poh_burst_fsm.sv
module poh_burst_fsm
    import poh_pkg::*;
#(
    parameter int SLOTS   = 28,
    parameter int STAT_W  = 34,
    localparam int BURST_W = SLOTS * 8,
    localparam int CNT_W   = $clog2(BURST_W),
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int SW_W    = $clog2(STAT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic [STAT_W-1:0] stat_in,
    input  logic [1:0]        phase,
    input  logic [7:0]        rd_byte,
    output logic [2:0]        rd_field,
    output logic [SLOT_W-1:0] rd_slot,
    output logic              ser_data,
    output logic              ser_valid
);

    fsm_t              state, state_n;
    burst_t            cur_type, type_n, nxt_type;
    logic [2:0]        bidx, bidx_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [STAT_W-1:0] stat_q;
    logic              last;
    logic [2:0]        hdr_v;
    logic [SW_W-1:0]   sidx;

    // next-state logic
    always_comb begin
        state_n  = state;
        cnt_n    = cnt;
        bidx_n   = bidx;
        type_n   = cur_type;
        last     = 1'b0;
        nxt_type = sched_pick(phase, 3'(bidx + 3'd1));
        unique case (state)
            S_IDLE: ;
            S_HDR: begin
                if (cnt == CNT_W'(HDR_W - 1)) begin
                    cnt_n   = '0;
                    state_n = (cur_type == T_STAT) ? S_STAT : S_OH;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            S_STAT: begin
                if (cnt == CNT_W'(STAT_W - 1)) last = 1'b1;
                else                           cnt_n = cnt + 1'b1;
            end
            S_OH: begin
                if (cnt == CNT_W'(BURST_W - 1)) last = 1'b1;
                else                            cnt_n = cnt + 1'b1;
            end
        endcase
        if (last) begin
            cnt_n = '0;
            if (nxt_type == T_NONE) begin
                state_n = S_IDLE;
            end else begin
                state_n = S_HDR;
                bidx_n  = 3'(bidx + 3'd1);
                type_n  = nxt_type;
            end
        end
        if (frame_sync) begin
            state_n = S_HDR;
            cnt_n   = '0;
            bidx_n  = '0;
            type_n  = T_STAT;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt      <= '0;
            bidx     <= '0;
            cur_type <= T_NONE;
            stat_q   <= '0;
        end else begin
            state    <= state_n;
            cnt      <= cnt_n;
            bidx     <= bidx_n;
            cur_type <= type_n;
            if (frame_sync) stat_q <= stat_in;
        end
    end

    // outputs
    always_comb begin
        hdr_v     = cur_type;
        sidx      = SW_W'(STAT_W - 1) - cnt[SW_W-1:0];
        rd_field  = 3'(hdr_v - 3'(T_V5));
        rd_slot   = cnt[CNT_W-1:3];
        ser_valid = (state != S_IDLE);
        ser_data  = 1'b0;
        unique case (state)
            S_IDLE: ser_data = 1'b0;
            S_HDR:  ser_data = hdr_v[2'd2 - cnt[1:0]];
            S_STAT: ser_data = stat_q[sidx];
            S_OH:   ser_data = rd_byte[3'd7 - cnt[2:0]];
        endcase
    end

endmodule

// File: rtl/poh_serial_export.sv
module poh_serial_export
    import poh_pkg::*;
#(
    parameter int NUM_TRIB = 28,
    parameter int SLOTS    = 28,
    parameter int STAT_W   = 34
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_sync,
    input  logic                     mf_first,
    input  logic [STAT_W-1:0]        stat_in,
    input  logic                     wr_en,
    input  logic [2:0]               wr_sel,
    input  logic [$clog2(SLOTS)-1:0] wr_trib,
    input  logic [7:0]               wr_data,
    output logic                     ser_data,
    output logic                     ser_valid
);

    localparam int SLOT_W = $clog2(SLOTS);

    logic [1:0]        phase;
    logic              cap_bank;
    logic [2:0]        rd_field;
    logic [SLOT_W-1:0] rd_slot;
    logic [7:0]        rd_byte;

    poh_phase_track u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .mf_first   (mf_first),
        .phase      (phase),
        .cap_bank   (cap_bank)
    );

    poh_bank_store #(
        .NUM_TRIB (NUM_TRIB),
        .SLOTS    (SLOTS)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_trib  (wr_trib),
        .wr_data  (wr_data),
        .cap_bank (cap_bank),
        .rd_field (rd_field),
        .rd_slot  (rd_slot),
        .rd_byte  (rd_byte)
    );

    poh_burst_fsm #(
        .SLOTS  (SLOTS),
        .STAT_W (STAT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .stat_in    (stat_in),
        .phase      (phase),
        .rd_byte    (rd_byte),
        .rd_field   (rd_field),
        .rd_slot    (rd_slot),
        .ser_data   (ser_data),
        .ser_valid  (ser_valid)
    );

endmodule

// File: rtl/poh_serial_export_chk.sv
module poh_serial_export_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_sync,
    input logic       mf_first,
    input logic       ser_data,
    input logic       ser_valid,
    input logic [1:0] phase,
    input logic       cap_bank
);

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |-> !ser_data);

    p_sync_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> ser_valid);

    p_hdr_lead_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_valid) |-> !ser_data);

    p_restart_frame1_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && mf_first) |=> (phase == 2'd0));

    p_phase_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && !mf_first) |=> (phase == 2'($past(phase) + 2'd1)));

    p_phase_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |=> $stable(phase));

    p_swap_in_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_sync && phase == 2'd3) |=> (cap_bank != $past(cap_bank)));

    p_no_swap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_sync && phase == 2'd3) |=> $stable(cap_bank));

endmodule

bind poh_serial_export poh_serial_export_chk u_chk (.*);

// File: tb/poh_serial_export_test.sv
module poh_serial_export_test;

    localparam int CLK_PERIOD = 10;
    localparam int NT         = 21;
    localparam int SLOTS      = 28;
    localparam int FRAME_LEN  = 760;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync = 1'b0;
    logic        mf_first = 1'b0;
    logic [33:0] stat_in = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [4:0]  wr_trib = '0;
    logic [7:0]  wr_data = '0;
    logic        ser_data;
    logic        ser_valid;

    int    checks = 0;
    int    errors = 0;
    int    mdl [2][5][SLOTS];
    int    mcap = 0;
    int    mphase = 3;
    bit    rsv_hit [SLOTS];
    bit    in_reset = 1'b1;
    bit    qd [$];
    string qt [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    poh_serial_export #(.NUM_TRIB(NT)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .mf_first   (mf_first),
        .stat_in    (stat_in),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_trib    (wr_trib),
        .wr_data    (wr_data),
        .ser_data   (ser_data),
        .ser_valid  (ser_valid)
    );

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push(bit d, string t);
        qd.push_back(d);
        qt.push_back(t);
    endtask

    task automatic build(bit abort, bit restart, logic [33:0] st);
        int    rb;
        int    list [$];
        string ht;
        rb = 1 - mcap;
        case (mphase)
            0:       list = '{1, 2, 3, 4};
            1:       list = '{1, 5, 6};
            default: list = '{1};
        endcase
        for (int i = 0; i < list.size(); i++) begin
            ht = restart ? "R10" : ((i == 0) ? "R4" : "R3");
            for (int h = 2; h >= 0; h--) push(bit'((list[i] >> h) & 1), ht);
            if (list[i] == 1) begin
                for (int b = 33; b >= 0; b--) push(st[b], abort ? "R11" : "R1");
            end else begin
                for (int b = 0; b < SLOTS * 8; b++) begin
                    int s;
                    s = b / 8;
                    if (s >= NT) begin
                        push(1'b0, "R8");
                    end else begin
                        string dt;
                        dt = rsv_hit[s] ? "R9" :
                             (list[i] == 6) ? "R7" :
                             (list[i] == 4 || list[i] == 5) ? "R2" : "R6";
                        push(bit'((mdl[rb][list[i] - 2][s] >> (7 - b % 8)) & 1), dt);
                    end
                end
            end
        end
    endtask

    task automatic compare();
        int act;
        act = int'({ser_valid, ser_data});
        if (qd.size() > 0) begin
            bit    e;
            string t;
            e = qd.pop_front();
            t = qt.pop_front();
            check(ser_valid === 1'b1 && ser_data === e, t, act, 2 + int'(e));
        end else begin
            check(ser_valid === 1'b0 && ser_data === 1'b0,
                  in_reset ? "R12" : "R5", act, 0);
        end
    endtask

    // one clock: drive inputs, update the model for the coming edge, compare after it
    task automatic cycle(bit fs, bit mf, bit we, int sel, int trib, int data, logic [33:0] st);
        frame_sync = fs;
        mf_first   = mf;
        wr_en      = we;
        wr_sel     = 3'(sel);
        wr_trib    = 5'(trib);
        wr_data    = 8'(data);
        stat_in    = st;
        if (we && trib < NT) begin
            case (sel)
                0, 1, 2, 3: mdl[mcap][sel][trib] = data & 255;
                4:          mdl[mcap][4][trib] = (mdl[mcap][4][trib] & 'h0F) | ((data & 'hF) << 4);
                5:          mdl[mcap][4][trib] = (mdl[mcap][4][trib] & 'hF0) | (data & 'hF);
                default:    rsv_hit[trib] = 1'b1;
            endcase
        end
        if (fs) begin
            bit abort, in_seq, restart;
            abort   = (qd.size() > 0);
            in_seq  = (mphase == 3);
            restart = mf && !in_seq;
            if (mf || in_seq) mphase = 0;
            else              mphase = mphase + 1;
            if (in_seq) mcap = 1 - mcap;
            qd.delete();
            qt.delete();
            build(abort, restart, st);
        end
        @(negedge clk);
        compare();
    endtask

    task automatic frame(bit mf, int len);
        logic [33:0] st;
        st = {2'($urandom), 32'($urandom)};
        cycle(1'b1, mf, 1'b0, 0, 0, 0, st);
        for (int k = 1; k < len; k++) begin
            bit we;
            we = ($urandom % 3) == 0;
            cycle(1'b0, (k % 97) == 5, we, int'($urandom % 8), int'($urandom % SLOTS),
                  int'($urandom % 256), {2'($urandom), 32'($urandom)});
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL R5 watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++)
            for (int f = 0; f < 5; f++)
                for (int t = 0; t < SLOTS; t++) mdl[b][f][t] = 0;
        for (int t = 0; t < SLOTS; t++) rsv_hit[t] = 1'b0;

        repeat (3) @(negedge clk);
        compare();                          // R12: outputs idle while in reset
        rst_n = 1'b1;
        for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0, 1'b0, 0, 0, 0, '0);   // R12
        in_reset = 1'b0;

        // fill the capture bank, every field and tributary, reserved selects included
        for (int t = 0; t < SLOTS; t++)
            for (int s = 0; s < 8; s++)
                cycle(1'b0, 1'b0, 1'b1, s, t, int'($urandom % 256), '0);

        frame(1'b1, FRAME_LEN);     // frame 1, in sequence: R2 swap, R3 order
        frame(1'b0, FRAME_LEN);     // frame 2
        frame(1'b0, FRAME_LEN);     // frame 3
        frame(1'b0, FRAME_LEN);     // frame 4
        frame(1'b1, FRAME_LEN);     // frame 1, second superframe
        frame(1'b0, FRAME_LEN);     // frame 2
        frame(1'b1, FRAME_LEN);     // R10: out-of-sequence start, no swap
        frame(1'b0, 300);           // frame 2 cut short by next sync
        frame(1'b0, FRAME_LEN);     // R11: abort restarts with status burst
        frame(1'b0, FRAME_LEN);     // frame 4
        frame(1'b0, FRAME_LEN);     // wrap into frame 1 without mf_first: R2 swap
        frame(1'b0, FRAME_LEN);     // frame 2
        for (int i = 0; i < 20; i++) cycle(1'b0, 1'b1, 1'b0, 0, 0, 0, '0);  // R10: mf_first alone
        for (int i = 0; i < 20; i++) cycle(1'b0, 1'b0, 1'b0, 0, 0, 0, '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule